// File: doc/BRIEF.md
# Programmable Regional Clock Divider

This block derives a slower clock from a fast input clock. The divide ratio is chosen on a 4-bit input and can be any whole value from 1 to 8. Even ratios give a symmetric output. Odd ratios give an output whose high phase is one input cycle longer than its low phase. A clock-enable input freezes the divider where it stands. An asynchronous clear input forces the divided clock low and restarts it. A bypass input routes the input clock straight to the output without any register stage, and in that mode the enable and clear inputs no longer matter.

The divided clock is kept as a register (`divClk`). Beside it the block gives a single-cycle marker (`risePulse`) for each rising edge of that register, so logic in the fast domain can line up with the slow one. The clock output (`clkOut`) selects between three sources. At ratio 2 or more it carries the register. At ratio 1 it carries the input clock gated by a registered enable. In bypass it carries the raw input clock. A new ratio is taken up only at the start of an output period, so the period in flight always completes at the old ratio.

Top module: `rclk_div`

## Requirements
- R1: `ratio` is 4 bits wide. Values 1 to 8 select that divide ratio. The values 0 and 9 to 15 behave exactly like ratio 1.
- R2: For an even ratio N, with `ce` high, `divClk` is high for N/2 input cycles and then low for N/2 input cycles, repeating.
- R3: For an odd ratio N of 3 or more, with `ce` high, `divClk` is high for (N+1)/2 input cycles and low for (N-1)/2 input cycles.
- R4: At ratio 1, `divClk` stays high and `clkOut` follows `clkIn` while enabled. One input edge after `ce` falls, `clkOut` is held low. One edge after `ce` rises again, `clkOut` follows `clkIn` once more.
- R5: While `ce` is low, `divClk` and the position within the period hold their values. When `ce` returns high, the period continues from the point where it stopped.
- R6: `clr` high forces `divClk` and `risePulse` low at once, without waiting for a clock edge. The first input edge with `ce` high after `clr` falls drives `divClk` high and begins a new period.
- R7: A change on `ratio` takes effect only when a new output period begins. The period already running finishes with the old high and low lengths.
- R8: With `bypass` high, `clkOut` equals `clkIn` and `risePulse` is held at 1. This holds whatever the values of `ce`, `clr` and `ratio`.
- R9: `risePulse` is high in exactly those input cycles where `divClk` has just gone high at the last edge, that is, the first cycle of each high phase. At ratio 1 with `ce` high, it is high in every cycle.
- R10: While `rstN` is low, `divClk`, `risePulse` and (with `bypass` low) `clkOut` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clkIn | input | 1 | Fast input clock |
| rstN | input | 1 | Asynchronous reset, active low |
| ce | input | 1 | Divider enable; low freezes the divider |
| clr | input | 1 | Asynchronous clear of the divider, active high |
| bypass | input | 1 | High routes clkIn straight to clkOut |
| ratio | input | 4 | Divide ratio, 1 to 8 (other values act as 1) |
| clkOut | output | 1 | Output clock (divided, gated or bypassed) |
| divClk | output | 1 | Registered divided clock |
| risePulse | output | 1 | High in the first cycle of each divClk high phase |

## Verification
A table walks every ratio from 1 to 8, plus the values 0 and 12, and measures the high and low run lengths of `divClk` from a fresh clear. This separates the even split from the odd split and shows which phase gets the extra cycle. It also confirms that illegal values fall back to ratio 1. Directed patterns cover the following cases:
- holding `ce` low mid-phase, to tell holding apart from restarting;
- asserting `clr` between edges, to show that the clear acts without a clock edge;
- changing `ratio` mid-period, to show the change is deferred to the next period;
- gating at ratio 1;
- bypass with `ce` low and `clr` high, to show that neither control reaches the output.

// File: rtl/rclk_div_pkg.sv
package rclk_div_pkg;

  // Strobes from the period control to the output datapath
  typedef struct packed {
    logic load;      // a new output period starts at this edge
    logic step;      // advance one cycle inside the current period
    logic highNext;  // output level for the cycle being entered on a step
    logic unitMode;  // active ratio is 1: pass the gated input clock
  } divStrobe_t;

endpackage

// File: rtl/rclk_div_ctrl.sv
module rclk_div_ctrl
  import rclk_div_pkg::*;
#(
  parameter int MAX_RATIO = 8,
  parameter int RATIO_W   = 4
) (
  input  logic               clkIn,
  input  logic               rstN,
  input  logic               clr,
  input  logic               ce,
  input  logic [RATIO_W-1:0] ratio,
  output divStrobe_t         strb
);

  localparam int CNT_W = (MAX_RATIO > 1) ? $clog2(MAX_RATIO) : 1;

  logic               running;
  logic [CNT_W-1:0]   cnt;
  logic [RATIO_W-1:0] activeRatio;
  logic [RATIO_W-1:0] legalRatio;
  logic [RATIO_W-1:0] highLen;
  logic [RATIO_W-1:0] cntWide;
  logic [RATIO_W-1:0] cntPlus;
  logic               lastCycle;
  logic               doLoad;
  logic               doStep;

  // Out-of-range requests fall back to a ratio of one
  always_comb begin
    if (ratio == '0 || ratio > RATIO_W'(MAX_RATIO)) legalRatio = RATIO_W'(1);
    else                                             legalRatio = ratio;
  end

  assign cntWide   = RATIO_W'(cnt);
  assign cntPlus   = cntWide + RATIO_W'(1);
  // The high phase takes the extra cycle on odd ratios
  assign highLen   = (activeRatio + RATIO_W'(1)) >> 1;
  assign lastCycle = (cntWide == activeRatio - RATIO_W'(1));
  assign doLoad    = ce & (~running | lastCycle);
  assign doStep    = ce & ~doLoad;

  always_ff @(posedge clkIn or negedge rstN or posedge clr) begin
    if (!rstN || clr) begin
      running     <= 1'b0;
      cnt         <= '0;
      activeRatio <= RATIO_W'(1);
    end else if (doLoad) begin
      running     <= 1'b1;
      cnt         <= '0;
      activeRatio <= legalRatio;
    end else if (doStep) begin
      cnt         <= cnt + 1'b1;
    end
  end

  always_comb begin
    strb.load     = doLoad;
    strb.step     = doStep;
    strb.highNext = (cntPlus < highLen);
    strb.unitMode = (activeRatio == RATIO_W'(1));
  end

  // Position never leaves the active period
  assert_cnt_in_range_R1: assert property (@(posedge clkIn) disable iff (!rstN || clr)
    cntWide < activeRatio);

  // Active ratio always legal
  assert_ratio_legal_R1: assert property (@(posedge clkIn) disable iff (!rstN || clr)
    (activeRatio != '0) && (activeRatio <= RATIO_W'(MAX_RATIO)));

  // Disabled divider keeps its place
  assert_ce_hold_R5: assert property (@(posedge clkIn) disable iff (!rstN || clr)
    !ce |=> $stable(cnt) && $stable(activeRatio) && $stable(running));

  // Ratio changes only at a period start
  assert_ratio_on_wrap_R7: assert property (@(posedge clkIn) disable iff (!rstN || clr)
    (running && !doLoad) |=> $stable(activeRatio));

endmodule

// File: rtl/rclk_div_dp.sv
module rclk_div_dp
  import rclk_div_pkg::*;
(
  input  logic       clkIn,
  input  logic       rstN,
  input  logic       clr,
  input  logic       ce,
  input  logic       bypass,
  input  divStrobe_t strb,
  output logic       clkOut,
  output logic       divClk,
  output logic       risePulse
);

  logic divOut;
  logic riseReg;
  logic oneGate;

  always_ff @(posedge clkIn or negedge rstN or posedge clr) begin
    if (!rstN || clr) begin
      divOut  <= 1'b0;
      riseReg <= 1'b0;
      oneGate <= 1'b0;
    end else begin
      oneGate <= ce;
      if (strb.load) begin
        divOut  <= 1'b1;
        riseReg <= 1'b1;
      end else if (strb.step) begin
        divOut  <= strb.highNext;
        riseReg <= 1'b0;
      end else begin
        riseReg <= 1'b0;
      end
    end
  end

  // Bypass has no register between clkIn and clkOut
  always_comb begin
    if (bypass)             clkOut = clkIn;
    else if (strb.unitMode) clkOut = clkIn & divOut & oneGate;
    else                    clkOut = divOut;
  end

  assign divClk    = divOut;
  assign risePulse = bypass | riseReg;

  // Marker only during a high phase
  assert_rise_in_high_R9: assert property (@(posedge clkIn) disable iff (!rstN || clr)
    riseReg |-> divOut);

  // Clear drives the divided clock low
  assert_clr_low_R6: assert property (@(posedge clkIn) disable iff (!rstN)
    clr |-> (!divOut && !riseReg));

  // Output level frozen while disabled
  assert_hold_out_R5: assert property (@(posedge clkIn) disable iff (!rstN || clr)
    !ce |=> $stable(divOut) && !riseReg);

endmodule

// File: rtl/rclk_div.sv
module rclk_div
  import rclk_div_pkg::*;
#(
  parameter int MAX_RATIO = 8,
  parameter int RATIO_W   = 4
) (
  input  logic               clkIn,
  input  logic               rstN,
  input  logic               ce,
  input  logic               clr,
  input  logic               bypass,
  input  logic [RATIO_W-1:0] ratio,
  output logic               clkOut,
  output logic               divClk,
  output logic               risePulse
);

  divStrobe_t strb;

  rclk_div_ctrl #(
    .MAX_RATIO (MAX_RATIO),
    .RATIO_W   (RATIO_W)
  ) uCtrl (
    .clkIn (clkIn),
    .rstN  (rstN),
    .clr   (clr),
    .ce    (ce),
    .ratio (ratio),
    .strb  (strb)
  );

  rclk_div_dp uDp (
    .clkIn     (clkIn),
    .rstN      (rstN),
    .clr       (clr),
    .ce        (ce),
    .bypass    (bypass),
    .strb      (strb),
    .clkOut    (clkOut),
    .divClk    (divClk),
    .risePulse (risePulse)
  );

endmodule

// File: tb/rclk_div_test.sv
module rclk_div_test;

  logic       clkIn = 1'b0;
  logic       rstN;
  logic       ce;
  logic       clr;
  logic       bypass;
  logic [3:0] ratio;
  logic       clkOut;
  logic       divClk;
  logic       risePulse;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clkIn = ~clkIn;

  rclk_div uut (
    .clkIn     (clkIn),
    .rstN      (rstN),
    .ce        (ce),
    .clr       (clr),
    .bypass    (bypass),
    .ratio     (ratio),
    .clkOut    (clkOut),
    .divClk    (divClk),
    .risePulse (risePulse)
  );

  typedef struct packed {
    int rq;   // requested ratio
    int hi;   // expected high cycles, 0 = ratio-one behaviour
    int lo;   // expected low cycles
  } vec_t;

  localparam vec_t VECS [10] = '{
    '{rq: 1,  hi: 0, lo: 0},
    '{rq: 2,  hi: 1, lo: 1},
    '{rq: 3,  hi: 2, lo: 1},
    '{rq: 4,  hi: 2, lo: 2},
    '{rq: 5,  hi: 3, lo: 2},
    '{rq: 6,  hi: 3, lo: 3},
    '{rq: 7,  hi: 4, lo: 3},
    '{rq: 8,  hi: 4, lo: 4},
    '{rq: 0,  hi: 0, lo: 0},
    '{rq: 12, hi: 0, lo: 0}
  };

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic sampleEdge();
    @(posedge clkIn);
    #1;
  endtask

  // Clear for one cycle with a new ratio, then sample the first enabled edge
  task automatic restart(input int r);
    @(negedge clkIn);
    ratio = 4'(r);
    clr   = 1'b1;
    @(negedge clkIn);
    clr   = 1'b0;
    sampleEdge();
  endtask

  task automatic measure(output int hi, output int lo);
    hi = 0;
    lo = 0;
    while (divClk == 1'b1 && hi < 20) begin
      hi++;
      sampleEdge();
    end
    while (divClk == 1'b0 && lo < 20) begin
      lo++;
      sampleEdge();
    end
  endtask

  initial begin
    repeat (100000) @(posedge clkIn);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int hi;
    int lo;
    rstN   = 1'b0;
    ce     = 1'b1;
    clr    = 1'b0;
    bypass = 1'b0;
    ratio  = 4'd3;

    // R10 reset state
    repeat (2) sampleEdge();
    check("R10", "divClk in reset", int'(divClk), 0);
    check("R10", "risePulse in reset", int'(risePulse), 0);
    check("R10", "clkOut in reset", int'(clkOut), 0);
    @(negedge clkIn);
    rstN = 1'b1;

    // Ratio table: phase lengths for every legal ratio and two illegal ones
    foreach (VECS[i]) begin
      restart(VECS[i].rq);
      check("R9", "risePulse at first edge", int'(risePulse), 1);
      if (VECS[i].hi == 0) begin
        for (int k = 0; k < 4; k++) begin
          check((VECS[i].rq == 1) ? "R4" : "R1", "unit divClk high", int'(divClk), 1);
          check((VECS[i].rq == 1) ? "R4" : "R1", "unit clkOut high phase", int'(clkOut), 1);
          check("R9", "unit risePulse every cycle", int'(risePulse), 1);
          @(negedge clkIn);
          #1;
          check((VECS[i].rq == 1) ? "R4" : "R1", "unit clkOut low phase", int'(clkOut), 0);
          sampleEdge();
        end
      end else begin
        measure(hi, lo);
        check((VECS[i].hi == VECS[i].lo) ? "R2" : "R3", $sformatf("ratio %0d high", VECS[i].rq), hi, VECS[i].hi);
        check((VECS[i].hi == VECS[i].lo) ? "R2" : "R3", $sformatf("ratio %0d low", VECS[i].rq), lo, VECS[i].lo);
        check("R9", "risePulse at next period", int'(risePulse), 1);
        sampleEdge();
        check("R9", "risePulse one cycle only", int'(risePulse), 0);
      end
    end

    // R5: hold mid high phase at ratio 6, resume where stopped
    restart(6);
    sampleEdge();
    @(negedge clkIn);
    ce = 1'b0;
    repeat (5) sampleEdge();
    check("R5", "divClk held while disabled", int'(divClk), 1);
    check("R5", "no risePulse while disabled", int'(risePulse), 0);
    @(negedge clkIn);
    ce = 1'b1;
    sampleEdge();
    measure(hi, lo);
    check("R5", "remaining high after resume", hi, 1);
    check("R5", "low after resume", lo, 3);

    // R6: asynchronous clear mid high phase
    restart(6);
    @(negedge clkIn);
    clr = 1'b1;
    #1;
    check("R6", "divClk cleared without edge", int'(divClk), 0);
    check("R6", "risePulse cleared", int'(risePulse), 0);
    @(negedge clkIn);
    clr = 1'b0;
    sampleEdge();
    check("R6", "divClk rises on first enabled edge", int'(divClk), 1);
    check("R6", "risePulse after clear", int'(risePulse), 1);

    // R7: ratio change deferred to next period
    restart(4);
    @(negedge clkIn);
    ratio = 4'd8;
    #1;
    measure(hi, lo);
    check("R7", "old period high", hi, 2);
    check("R7", "old period low", lo, 2);
    measure(hi, lo);
    check("R7", "new period high", hi, 4);
    check("R7", "new period low", lo, 4);

    // R4: gating at ratio one
    restart(1);
    @(negedge clkIn);
    ce = 1'b0;
    sampleEdge();
    check("R4", "clkOut stopped after ce low", int'(clkOut), 0);
    sampleEdge();
    check("R4", "clkOut still stopped", int'(clkOut), 0);
    @(negedge clkIn);
    ce = 1'b1;
    sampleEdge();
    check("R4", "clkOut resumes", int'(clkOut), 1);

    // R8: bypass ignores ce, clr and ratio
    @(negedge clkIn);
    bypass = 1'b1;
    ce     = 1'b0;
    clr    = 1'b1;
    ratio  = 4'd5;
    for (int k = 0; k < 3; k++) begin
      sampleEdge();
      check("R8", "bypass clkOut high", int'(clkOut), 1);
      check("R8", "bypass risePulse", int'(risePulse), 1);
      @(negedge clkIn);
      #1;
      check("R8", "bypass clkOut low", int'(clkOut), 0);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule